// File: doc/BRIEF.md
# Graphics DMA Protection Guard

This block decides, in the same cycle, whether a DMA access issued by the graphics engine may proceed. It holds one protection word. Each field of that word either closes a fixed window or sets how far a protected region reaches down from a fixed ceiling. The guarded memories are a main memory bank, an extended memory bank, a small fast work RAM and an auxiliary memory. The main and extended regions grow in 8 MiB steps and the auxiliary region grows in 1 MiB steps.

Software writes the protection word through a simple write port and can read it back. The graphics side presents an address with a valid strobe. In the same cycle the block raises either a grant or a deny. The bank base addresses are fixed: main memory is 0x20000000 to 0x27FFFFFF, extended memory is 0x28000000 to 0x2FFFFFFF, work RAM is 0x1FF80000 to 0x1FFFFFFF and auxiliary memory is 0x1F000000 to 0x1F3FFFFF.

Top module: `gdg_top`

## Requirements
- R1: After reset the protection word reads 0x00000000 and every address is granted.
- R2: With main count x (word bits 3:0) nonzero, addresses from 0x28000000 - x*0x800000 to 0x27FFFFFF are denied, and lower main addresses are granted.
- R3: Main addresses 0x20000000 to 0x207FFFFF are granted for every value of the word.
- R4: With extended count y (word bits 7:4) nonzero, addresses from 0x30000000 - y*0x800000 to 0x2FFFFFFF are denied.
- R5: While x is nonzero, addresses 0x28000000 to 0x287FFFFF are denied whatever y holds.
- R6: While word bit 8 is 1, every work RAM address is denied. While it is 0, work RAM is granted.
- R7: With auxiliary count z (word bits 10:9) nonzero, addresses from 0x1F400000 - z*0x100000 to 0x1F3FFFFF are denied.
- R8: Word bits 31:11 always read as zero, whatever was written to them.
- R9: A write changes the readback and the decision from the cycle after the write. In the cycle of the write itself, requests are judged with the old value.
- R10: Addresses outside all four memories are always granted.
- R11: Grant and deny are never high together, and both stay low while valid is low. With valid high, exactly one of them is high in that same cycle.
- R12: The main and extended cutoffs may be active together, and the denied set is the union of their ranges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Write strobe for the protection word |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Current protection word |
| req_valid_i | input | 1 | Request valid |
| req_addr_i | input | 32 | Request byte address |
| req_grant_o | output | 1 | Access permitted (same cycle) |
| req_deny_o | output | 1 | Access refused (same cycle) |

## Verification
The decision path has no state of its own. A wrong stored field therefore shows at the ports on the very next request that falls near a region boundary, and it shows on the readback port one cycle after the write. The hardest errors to spot are off-by-one step arithmetic, a missing 8 MiB guard at the bottom of main memory, and a missing spill-over into the head of the extended bank. For that reason the tests probe both sides of every computed bound and sweep the main count over all sixteen values.

// File: rtl/gdg_pkg.sv
package gdg_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned MAIN_CNT_W = 4;
  localparam int unsigned EXT_CNT_W  = 4;
  localparam int unsigned AUX_CNT_W  = 2;
  localparam int unsigned CFG_W = MAIN_CNT_W + EXT_CNT_W + 1 + AUX_CNT_W;

  // Field order sets bit positions: main [3:0], ext [7:4], wram [8], aux [10:9]
  typedef struct packed {
    logic [AUX_CNT_W-1:0]  aux_cnt;
    logic                  wram_lock;
    logic [EXT_CNT_W-1:0]  ext_cnt;
    logic [MAIN_CNT_W-1:0] main_cnt;
  } gdg_cfg_t;

  localparam logic [ADDR_W-1:0] MAIN_LO  = 32'h2000_0000;
  localparam logic [ADDR_W-1:0] MAIN_CEIL = 32'h2800_0000;
  localparam logic [ADDR_W-1:0] EXT_LO   = 32'h2800_0000;
  localparam logic [ADDR_W-1:0] EXT_CEIL = 32'h3000_0000;
  localparam logic [ADDR_W-1:0] WRAM_LO  = 32'h1FF8_0000;
  localparam logic [ADDR_W-1:0] WRAM_CEIL = 32'h2000_0000;
  localparam logic [ADDR_W-1:0] AUX_LO   = 32'h1F00_0000;
  localparam logic [ADDR_W-1:0] AUX_CEIL = 32'h1F40_0000;
  localparam int unsigned BIG_STEP_LOG2 = 23;
  localparam int unsigned AUX_STEP_LOG2 = 20;
  localparam logic [ADDR_W-1:0] BIG_STEP = 32'h0080_0000;
endpackage

// File: rtl/gdg_cfg_reg.sv
module gdg_cfg_reg
  import gdg_pkg::*;
#(
  parameter int unsigned WORD_W = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [WORD_W-1:0] wdata_i,
  output gdg_cfg_t          cfg_o,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = WORD_W - CFG_W;

  // reset synchronizer: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_nq;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q  <= 1'b0;
      rst_sync_nq <= 1'b0;
    end else begin
      rst_meta_q  <= 1'b1;
      rst_sync_nq <= rst_meta_q;
    end
  end

  gdg_cfg_t cfg_q, cfg_d;
  logic     cfg_en;

  always_comb begin
    cfg_en = we_i;
    cfg_d  = gdg_cfg_t'(wdata_i[CFG_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_sync_nq) begin
    if (!rst_sync_nq) begin
      cfg_q <= '0;
    end else if (cfg_en) begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign rdata_o = {{PAD_W{1'b0}}, cfg_q};

  // R9: a write is visible on readback in the following cycle
  a_r9_write_lands: assert property (@(posedge clk_i) disable iff (!rst_sync_nq)
    we_i |=> (rdata_o == {{PAD_W{1'b0}}, $past(wdata_i[CFG_W-1:0])}));
  // R9: without a write the word holds
  a_r9_word_holds: assert property (@(posedge clk_i) disable iff (!rst_sync_nq)
    !we_i |=> $stable(rdata_o));
endmodule

// File: rtl/gdg_cutoff.sv
module gdg_cutoff
  import gdg_pkg::*;
#(
  parameter int unsigned       CNT_W     = 4,
  parameter logic [ADDR_W-1:0] REGION_LO = 32'h2000_0000,
  parameter logic [ADDR_W-1:0] CEIL      = 32'h2800_0000,
  parameter int unsigned       STEP_LOG2 = 23,
  parameter logic [ADDR_W-1:0] GUARD     = 32'h0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              hit_o
);
  localparam int unsigned XW = ADDR_W + 1;
  localparam logic [XW-1:0] CEIL_X  = {1'b0, CEIL};
  localparam logic [XW-1:0] FLOOR_X = {1'b0, REGION_LO} + {1'b0, GUARD};

  logic [XW-1:0] span, cut_lo, lo_eff, addr_x;
  logic          wrapped, active;

  always_comb begin
    addr_x  = {1'b0, addr_i};
    span    = {{(XW-CNT_W){1'b0}}, cnt_i} << STEP_LOG2;
    cut_lo  = CEIL_X - span;
    wrapped = span > CEIL_X;
    // the bottom guard band is never protected
    lo_eff  = (wrapped || cut_lo < FLOOR_X) ? FLOOR_X : cut_lo;
    active  = cnt_i != '0;
    hit_o   = active && (addr_x >= lo_eff) && (addr_x < CEIL_X);
  end
endmodule

// File: rtl/gdg_window.sv
module gdg_window
  import gdg_pkg::*;
#(
  parameter logic [ADDR_W-1:0] LO      = 32'h1FF8_0000,
  parameter logic [ADDR_W-1:0] HI_EXCL = 32'h2000_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              en_i,
  output logic              hit_o
);
  assign hit_o = en_i && (addr_i >= LO) && (addr_i < HI_EXCL);
endmodule

// File: rtl/gdg_top.sv
module gdg_top
  import gdg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_grant_o,
  output logic              req_deny_o
);
  localparam int unsigned N_CUT = 3;
  localparam int unsigned N_WIN = 2;

  gdg_cfg_t cfg;
  logic [N_CUT-1:0] cut_hit;
  logic [N_WIN-1:0] win_hit;
  logic             any_hit;

  gdg_cfg_reg #(.WORD_W(DATA_W)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .wdata_i(cfg_wdata_i),
    .cfg_o  (cfg),
    .rdata_o(cfg_rdata_o)
  );

  gdg_cutoff #(.CNT_W(MAIN_CNT_W), .REGION_LO(MAIN_LO), .CEIL(MAIN_CEIL),
               .STEP_LOG2(BIG_STEP_LOG2), .GUARD(BIG_STEP)) u_main_cut (
    .addr_i(req_addr_i), .cnt_i(cfg.main_cnt), .hit_o(cut_hit[0]));

  gdg_cutoff #(.CNT_W(EXT_CNT_W), .REGION_LO(EXT_LO), .CEIL(EXT_CEIL),
               .STEP_LOG2(BIG_STEP_LOG2), .GUARD('0)) u_ext_cut (
    .addr_i(req_addr_i), .cnt_i(cfg.ext_cnt), .hit_o(cut_hit[1]));

  gdg_cutoff #(.CNT_W(AUX_CNT_W), .REGION_LO(AUX_LO), .CEIL(AUX_CEIL),
               .STEP_LOG2(AUX_STEP_LOG2), .GUARD('0)) u_aux_cut (
    .addr_i(req_addr_i), .cnt_i(cfg.aux_cnt), .hit_o(cut_hit[2]));

  // fixed windows: work RAM lock and extended-bank head covered by main cutoff
  gdg_window #(.LO(WRAM_LO), .HI_EXCL(WRAM_CEIL)) u_wram_win (
    .addr_i(req_addr_i), .en_i(cfg.wram_lock), .hit_o(win_hit[0]));

  gdg_window #(.LO(EXT_LO), .HI_EXCL(EXT_LO + BIG_STEP)) u_ext_head_win (
    .addr_i(req_addr_i), .en_i(cfg.main_cnt != '0), .hit_o(win_hit[1]));

  assign any_hit     = (|cut_hit) || (|win_hit);
  assign req_deny_o  = req_valid_i && any_hit;
  assign req_grant_o = req_valid_i && !any_hit;

  // R11: exactly one answer per valid request, none otherwise
  a_r11_one_answer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({req_grant_o, req_deny_o}) == {1'b0, req_valid_i});
  // R3: bottom 8 MiB of main memory is never refused
  a_r3_main_floor_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i >= MAIN_LO && req_addr_i < MAIN_LO + BIG_STEP)
      |-> req_grant_o);
  // R10: addresses outside every guarded memory pass
  a_r10_outside_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (req_addr_i < AUX_LO || req_addr_i >= EXT_CEIL ||
     (req_addr_i >= AUX_CEIL && req_addr_i < WRAM_LO))) |-> req_grant_o);
  // R6: locked work RAM is refused
  a_r6_wram_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cfg_rdata_o[8] && req_addr_i >= WRAM_LO &&
     req_addr_i < WRAM_CEIL) |-> req_deny_o);
  // R5: nonzero main count refuses the extended head
  a_r5_ext_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && cfg_rdata_o[3:0] != 4'd0 && req_addr_i >= EXT_LO &&
     req_addr_i < EXT_LO + BIG_STEP) |-> req_deny_o);
endmodule

// File: tb/gdg_top_tb_top.sv
module gdg_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [31:0] cfg_wdata_i = '0;
  logic [31:0] cfg_rdata_o;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic        req_grant_o, req_deny_o;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] shadow = '0;

  always #2.5 clk_i = ~clk_i;

  gdg_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .cfg_rdata_o(cfg_rdata_o),
    .req_valid_i(req_valid_i), .req_addr_i(req_addr_i),
    .req_grant_o(req_grant_o), .req_deny_o(req_deny_o)
  );

  function automatic bit expect_deny(logic [31:0] c, logic [31:0] a);
    longint x = c[3:0], y = c[7:4], z = c[10:9];
    longint aa = a;
    bit d = 0;
    if (x != 0 && aa >= 64'h2080_0000 && aa < 64'h2800_0000 &&
        aa >= 64'h2800_0000 - x * 64'h80_0000) d = 1;
    if (y != 0 && aa < 64'h3000_0000 && aa >= 64'h3000_0000 - y * 64'h80_0000) d = 1;
    if (x != 0 && aa >= 64'h2800_0000 && aa < 64'h2880_0000) d = 1;
    if (c[8] && aa >= 64'h1FF8_0000 && aa < 64'h2000_0000) d = 1;
    if (z != 0 && aa < 64'h1F40_0000 && aa >= 64'h1F40_0000 - z * 64'h10_0000) d = 1;
    return d;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic write_word(logic [31:0] v);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = v;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    shadow = v & 32'h7FF;
  endtask

  task automatic probe(string tag, logic [31:0] a);
    bit d;
    @(negedge clk_i);
    req_valid_i = 1'b1; req_addr_i = a;
    #1;
    d = expect_deny(shadow, a);
    check({tag, " deny"}, {31'd0, req_deny_o}, {31'd0, d});
    check({tag, " grant"}, {31'd0, req_grant_o}, {31'd0, !d});
  endtask

  task automatic t_reset;
    @(negedge clk_i);
    check("R1 readback", cfg_rdata_o, 32'h0);
    probe("R1 main top", 32'h27FF_FFFC);
    probe("R1 wram", 32'h1FF8_0000);
    probe("R1 aux", 32'h1F3F_FFFF);
  endtask

  task automatic t_main;
    write_word(32'h1);
    probe("R2 x1 low edge", 32'h2780_0000);
    probe("R2 x1 below", 32'h277F_FFFF);
    probe("R2 x1 top", 32'h27FF_FFFF);
    write_word(32'hF);
    probe("R3 x15 floor top", 32'h207F_FFFF);
    probe("R3 x15 base", 32'h2000_0000);
    probe("R2 x15 above floor", 32'h2080_0000);
    for (int x = 0; x < 16; x++) begin
      write_word(x);
      probe("R2 sweep at bound", 32'h2800_0000 - x * 32'h80_0000);
      probe("R2 sweep under bound", 32'h27FF_FFFF - x * 32'h80_0000);
    end
  endtask

  task automatic t_ext;
    write_word(32'h20);
    probe("R4 y2 edge", 32'h2F00_0000);
    probe("R4 y2 below", 32'h2EFF_FFFF);
    probe("R4 head open when x0", 32'h2800_0000);
    write_word(32'hF0);
    probe("R4 y15 edge", 32'h2880_0000);
    probe("R4 y15 head open", 32'h287F_FFFF);
  endtask

  task automatic t_spill;
    write_word(32'h1);
    probe("R5 head start", 32'h2800_0000);
    probe("R5 head end", 32'h287F_FFFF);
    probe("R5 past head", 32'h2880_0000);
  endtask

  task automatic t_combo;
    write_word(32'h12);
    probe("R12 main part", 32'h2700_0000);
    probe("R12 main below", 32'h26FF_FFFF);
    probe("R12 ext part", 32'h2F80_0000);
    probe("R12 head", 32'h2840_0000);
    probe("R12 ext gap", 32'h2C00_0000);
  endtask

  task automatic t_wram;
    write_word(32'h100);
    probe("R6 lo", 32'h1FF8_0000);
    probe("R6 hi", 32'h1FFF_FFFF);
    probe("R6 below", 32'h1FF7_FFFF);
    write_word(32'h0);
    probe("R6 unlocked", 32'h1FFC_0000);
  endtask

  task automatic t_aux;
    write_word(32'h600);
    probe("R7 z3 edge", 32'h1F10_0000);
    probe("R7 z3 below", 32'h1F0F_FFFF);
    write_word(32'h200);
    probe("R7 z1 edge", 32'h1F30_0000);
    probe("R7 z1 below", 32'h1F2F_FFFF);
  endtask

  task automatic t_upper;
    write_word(32'hFFFF_FFFF);
    @(negedge clk_i);
    check("R8 readback", cfg_rdata_o, 32'h0000_07FF);
    probe("R10 zero", 32'h0000_0000);
    probe("R10 above ext", 32'h3000_0000);
    probe("R10 gap", 32'h1F40_0000);
    probe("R10 gap top", 32'h1FF7_FFFF);
    probe("R10 max", 32'hFFFF_FFFF);
    probe("R10 below aux", 32'h1EFF_FFFF);
  endtask

  task automatic t_timing;
    write_word(32'h0);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = 32'h1;
    req_valid_i = 1'b1; req_addr_i = 32'h27F0_0000;
    #1;
    check("R9 same-cycle old", {31'd0, req_grant_o}, 32'd1);
    check("R9 readback old", cfg_rdata_o, 32'h0);
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    #1;
    check("R9 next-cycle deny", {31'd0, req_deny_o}, 32'd1);
    check("R9 readback new", cfg_rdata_o, 32'h1);
    shadow = 32'h1;
  endtask

  task automatic t_valid;
    write_word(32'h1FF);
    @(negedge clk_i);
    req_valid_i = 1'b0; req_addr_i = 32'h1FF8_0000;
    #1;
    check("R11 idle deny", {31'd0, req_deny_o}, 32'd0);
    check("R11 idle grant", {31'd0, req_grant_o}, 32'd0);
    probe("R11 valid deny", 32'h1FF8_0000);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main_seq
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_main();
    t_ext();
    t_spill();
    t_combo();
    t_wram();
    t_aux();
    t_upper();
    t_timing();
    t_valid();
    @(negedge clk_i);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule